// File: doc/BRIEF.md
# Double-Buffered Frame Streamer

This block pulls one video frame of 16-bit pixels out of memory through a memory-mapped read master and sends it out on a valid/ready stream. Each frame becomes one packet: the first pixel carries a start marker and the last pixel carries an end marker. Fetched pixels pass through a small FIFO. A control machine issues reads only while the FIFO has room. It stops at an upper fill threshold and starts again at a lower one. It also limits the number of reads in flight, so that every return is sure to fit.

Two frame start addresses are held. The front address is the frame now being fetched, and the back address is the one queued behind it. Software loads the back address. It then writes the front register with any value, which asks for the two addresses to be exchanged. The exchange waits until the read for the last pixel of the current frame has been accepted. A status bit reads 1 while the exchange is waiting, so software knows when the old frame buffer is free to reuse.

Top module: `frame_dma_streamer`

## Requirements
- R1: After reset the front register reads FRONT_INIT, the back register reads BACK_INIT, the status register reads 0, and `st_valid` is 0.
- R2: Register reads return data on `reg_rdata` in the cycle after the `reg_rd` strobe. Select 0 is the front address (read-only), select 1 is the back address (read/write), select 2 is status with bit 0 = exchange pending, and select 3 reads 0.
- R3: Within a frame, pixel i comes from byte address front + 2*i (i = 0 .. FRAME_W*FRAME_H-1). Its value is `mem_rdata[15:0]` of that read. Pixels leave the stream in address order and none is lost or repeated.
- R4: `st_sop` is 1 only on pixel 0 of a frame and `st_eop` is 1 only on the last pixel. `st_empty` is always 0.
- R5: A write to select 0 leaves the front address unchanged and ignores the written data. From the next cycle on, status bit 0 reads 1.
- R6: The exchange happens in the cycle in which the read request for the last pixel of a frame is accepted. In that cycle front takes the back value, back takes the old front value, and status bit 0 clears. The following frame is fetched from the new front, and no frame mixes two base addresses.
- R7: A back write made while an exchange is pending is the value that moves to front. Several select-0 writes made before the exchange produce only one exchange.
- R8: While `mem_read` is 1 and `mem_wait` is 1, the request and its address are held unchanged in the next cycle.
- R9: Fetching stops once the FIFO level reaches AFULL and resumes once it falls to AEMPTY. Level plus reads in flight never exceeds FIFO_DEPTH, so no returned pixel is dropped under any stall of the sink.
- R10: While `st_valid` is 1 and `st_ready` is 0, the beat (data, sop, eop) stays on the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data, one cycle after `reg_rd` |
| mem_read | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the requested pixel |
| mem_wait | input | 1 | Memory stalls the current request |
| mem_rdata | input | 16 | Returned pixel |
| mem_rdv | input | 1 | `mem_rdata` is valid |
| st_data | output | 16 | Stream pixel |
| st_sop | output | 1 | First pixel of a frame |
| st_eop | output | 1 | Last pixel of a frame |
| st_empty | output | 1 | Empty-symbol count, always 0 |
| st_valid | output | 1 | Stream beat available |
| st_ready | input | 1 | Sink accepts the beat |

## Verification
The bench stalls the sink long enough for fetching to stop at the threshold, then posts an exchange request. If the design exchanged at once, the front address would change mid-frame and a packet would carry two bases. If it never exchanged, the status bit would stay stuck at 1. It also writes the back address while an exchange is pending and posts the request twice: a design that latched back at request time would stream the stale address, and one that counted requests would swap back again. A memory that inserts random wait states and returns data late catches an address that moves while held, and a level check during a long stall catches a FIFO that accepts more reads than it can hold.

// File: rtl/fds_pkg.sv
// Shared types for the frame streamer: FIFO word layout and register selects.
package fds_pkg;
    localparam int PIX_W = 16;

    // FIFO word: end marker in bit 17, start marker in bit 16, pixel in 15:0
    typedef struct packed {
        logic             eop;
        logic             sop;
        logic [PIX_W-1:0] pix;
    } fifo_word_t;

    localparam int WORD_W = $bits(fifo_word_t);

    typedef enum logic [1:0] {
        SEL_FRONT  = 2'd0,
        SEL_BACK   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/fds_regs.sv
// Register file of the frame streamer.
// Holds the front and back frame addresses and the pending-exchange flag.
// A front write is an exchange request and its data is dropped.
// Assumes frame_done is a single-cycle pulse from the fetch engine.
module fds_regs
    import fds_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] FRONT_INIT = 32'h0000_1000,
    parameter logic [31:0] BACK_INIT  = 32'h0000_2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              frame_done,
    output logic [ADDR_W-1:0] front_q,
    output logic [ADDR_W-1:0] back_q,
    output logic              pending_q
);
    logic wr_front;
    logic wr_back;
    logic swap;

    // Decode the write strobes and the exchange condition
    always_comb begin
        wr_front = reg_wr && (reg_sel_t'(reg_sel) == SEL_FRONT);
        wr_back  = reg_wr && (reg_sel_t'(reg_sel) == SEL_BACK);
        swap     = pending_q && frame_done;
    end

    // Front address: changes only through an exchange
    always_ff @(posedge clk) begin
        if (!rst_n)    front_q <= ADDR_W'(FRONT_INIT);
        else if (swap) front_q <= back_q;
    end

    // Back address: software write wins over the exchange
    always_ff @(posedge clk) begin
        if (!rst_n)       back_q <= ADDR_W'(BACK_INIT);
        else if (wr_back) back_q <= reg_wdata;
        else if (swap)    back_q <= front_q;
    end

    // Pending flag: set by a request, cleared by the exchange
    always_ff @(posedge clk) begin
        if (!rst_n)    pending_q <= 1'b0;
        else if (swap) pending_q <= wr_front;
        else           pending_q <= pending_q | wr_front;
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else if (reg_rd) begin
            case (reg_sel_t'(reg_sel))
                SEL_FRONT:  reg_rdata <= front_q;
                SEL_BACK:   reg_rdata <= back_q;
                SEL_STATUS: reg_rdata <= ADDR_W'(pending_q);
                default:    reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/fds_fetch.sv
// Fetch engine: issues pixel reads from the front address and tags returns.
// Keeps FIFO level between the thresholds with hysteresis and caps reads in
// flight so level plus outstanding never exceeds DEPTH.
// Assumes memory returns data in request order and only for accepted reads.
module fds_fetch
    import fds_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NPIX   = 12,
    parameter int DEPTH  = 16,
    parameter int AFULL  = 12,
    parameter int AEMPTY = 4,
    parameter int LVL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic [LVL_W-1:0]  level,
    output logic              mem_read,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wait,
    input  logic              mem_rdv,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic              frame_done,
    output logic              push,
    output fifo_word_t        push_word
);
    localparam int IDX_W   = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam int MAX_OUT = DEPTH - AFULL;
    localparam int OUT_W   = $clog2(MAX_OUT + 1);
    localparam int CNT_W   = OUT_W + 1;
    localparam int SUM_W   = LVL_W + 1;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] ret_q;
    logic [OUT_W-1:0] outst_q;
    logic             rd_q;
    logic             en_q;
    logic             accept;
    logic             last_pix;
    logic [SUM_W-1:0] pressure;
    logic             room_ok;
    logic             rd_n;

    // Request acceptance, frame end and room check
    always_comb begin
        accept     = rd_q && !mem_wait;
        last_pix   = (idx_q == IDX_W'(NPIX - 1));
        frame_done = accept && last_pix;
        pressure   = SUM_W'(level) + SUM_W'(outst_q) + SUM_W'(accept);
        room_ok    = (pressure < SUM_W'(DEPTH)) &&
                     ((CNT_W'(outst_q) + CNT_W'(accept)) < CNT_W'(MAX_OUT));
        rd_n       = (rd_q && !accept) || (en_q && room_ok);
    end

    // Request strobe: held until accepted
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_n;
    end

    // Hysteresis between the two fill thresholds
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= 1'b1;
        else if (level >= LVL_W'(AFULL))     en_q <= 1'b0;
        else if (level <= LVL_W'(AEMPTY))    en_q <= 1'b1;
    end

    // Pixel index of the next request, wraps at frame end
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (accept) idx_q <= last_pix ? '0 : idx_q + IDX_W'(1);
    end

    // Reads accepted but not yet returned
    always_ff @(posedge clk) begin
        if (!rst_n) outst_q <= '0;
        else        outst_q <= outst_q + OUT_W'(accept) - OUT_W'(mem_rdv);
    end

    // Position of the next returning pixel inside its frame
    always_ff @(posedge clk) begin
        if (!rst_n)       ret_q <= '0;
        else if (mem_rdv) ret_q <= (ret_q == IDX_W'(NPIX - 1)) ? '0 : ret_q + IDX_W'(1);
    end

    // Outputs: address from base and index, tagged FIFO word
    always_comb begin
        mem_read      = rd_q;
        mem_addr      = base + (ADDR_W'(idx_q) << 1);
        push          = mem_rdv;
        push_word.pix = mem_rdata;
        push_word.sop = (ret_q == '0);
        push_word.eop = (ret_q == IDX_W'(NPIX - 1));
    end
endmodule

// File: rtl/fds_fifo.sv
// Synchronous FIFO with a fill-level output.
// Assumes the writer never pushes when full (guaranteed by the fetch engine).
module fds_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_pop;

    // Pop only when a word is present
    always_comb begin
        empty  = (level == '0);
        do_pop = pop && !empty;
        rdata  = mem[rd_ptr];
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointers with explicit wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push)   wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (do_pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        end
    end

    // Fill level
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= level + LVL_W'(push) - LVL_W'(do_pop);
    end
endmodule

// File: rtl/frame_dma_streamer.sv
// Top of the double-buffered frame streamer.
// Registers -> fetch engine -> FIFO -> valid/ready stream, one packet per frame.
// Assumes in-order memory returns and FIFO_DEPTH > AFULL > AEMPTY.
module frame_dma_streamer
    import fds_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          FRAME_W    = 4,
    parameter int          FRAME_H    = 3,
    parameter int          FIFO_DEPTH = 16,
    parameter int          AFULL      = 12,
    parameter int          AEMPTY     = 4,
    parameter logic [31:0] FRONT_INIT = 32'h0000_1000,
    parameter logic [31:0] BACK_INIT  = 32'h0000_2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_read,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wait,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_rdv,
    output logic [15:0]       st_data,
    output logic              st_sop,
    output logic              st_eop,
    output logic              st_empty,
    output logic              st_valid,
    input  logic              st_ready
);
    localparam int NPIX  = FRAME_W * FRAME_H;
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic [ADDR_W-1:0] front_addr;
    logic [ADDR_W-1:0] back_addr;
    logic              swap_pending;
    logic              frame_done;
    logic              push;
    fifo_word_t        push_word;
    fifo_word_t        head_word;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_empty;
    logic              pop;

    fds_regs #(
        .ADDR_W(ADDR_W), .FRONT_INIT(FRONT_INIT), .BACK_INIT(BACK_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_done(frame_done), .front_q(front_addr), .back_q(back_addr),
        .pending_q(swap_pending)
    );

    fds_fetch #(
        .ADDR_W(ADDR_W), .NPIX(NPIX), .DEPTH(FIFO_DEPTH),
        .AFULL(AFULL), .AEMPTY(AEMPTY), .LVL_W(LVL_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .base(front_addr), .level(fifo_level),
        .mem_read(mem_read), .mem_addr(mem_addr), .mem_wait(mem_wait),
        .mem_rdv(mem_rdv), .mem_rdata(mem_rdata), .frame_done(frame_done),
        .push(push), .push_word(push_word)
    );

    fds_fifo #(
        .WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_word),
        .pop(pop), .rdata(head_word), .level(fifo_level), .empty(fifo_empty)
    );

    // Stream side: FIFO head drives the beat, transfer pops it
    always_comb begin
        st_valid = !fifo_empty;
        st_data  = head_word.pix;
        st_sop   = head_word.sop;
        st_eop   = head_word.eop;
        st_empty = 1'b0;
        pop      = st_valid && st_ready;
    end
endmodule

// File: rtl/fds_checker.sv
// Protocol and ordering properties of the frame streamer, bound to the top.
module fds_checker #(
    parameter int ADDR_W = 32,
    parameter int LVL_W  = 5,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic              reg_wr,
    input logic              mem_read,
    input logic              mem_wait,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rdv,
    input logic              st_valid,
    input logic              st_ready,
    input logic [15:0]       st_data,
    input logic              st_sop,
    input logic              st_eop,
    input logic [LVL_W-1:0]  level,
    input logic              frame_done,
    input logic [ADDR_W-1:0] front,
    input logic [ADDR_W-1:0] back,
    input logic              pending
);
    // R8: a stalled request is held with the same address
    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_read && mem_wait |=> mem_read && $stable(mem_addr));

    // R9: a returning pixel always finds room in the FIFO
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rdv && !(st_valid && st_ready) |-> level < LVL_W'(DEPTH));

    // R5: a front write raises the pending flag
    p_pending_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel == 2'd0 |=> pending);

    // R6: front moves only at a frame end
    p_front_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(front));

    // R6: a pending exchange completes at the frame end
    p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pending && frame_done && !(reg_wr && reg_sel == 2'd0)
        |=> !pending && front == $past(back));

    // R10: a refused beat stays on the outputs
    p_stream_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |=> st_valid && $stable(st_data)
                                  && $stable(st_sop) && $stable(st_eop));
endmodule

bind frame_dma_streamer fds_checker #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .mem_read(mem_read), .mem_wait(mem_wait), .mem_addr(mem_addr),
    .mem_rdv(mem_rdv), .st_valid(st_valid), .st_ready(st_ready),
    .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop),
    .level(fifo_level), .frame_done(frame_done), .front(front_addr),
    .back(back_addr), .pending(swap_pending)
);

// File: tb/tb_frame_dma_streamer.sv
// Directed bench: random-wait memory model, stalling sink, one task per scenario.
module tb_frame_dma_streamer;
    localparam int          ADDR_W = 32;
    localparam int          NPIX   = 12;
    localparam int          DEPTH  = 16;
    localparam int          AFULL  = 12;
    localparam logic [31:0] FRONT0 = 32'h0000_1000;
    localparam logic [31:0] BACK0  = 32'h0000_2000;

    logic              clk;
    logic              rst_n;
    logic [1:0]        reg_sel;
    logic              reg_wr;
    logic              reg_rd;
    logic [ADDR_W-1:0] reg_wdata;
    logic [ADDR_W-1:0] reg_rdata;
    logic              mem_read;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_wait;
    logic [15:0]       mem_rdata;
    logic              mem_rdv;
    logic [15:0]       st_data;
    logic              st_sop;
    logic              st_eop;
    logic              st_empty;
    logic              st_valid;
    logic              st_ready;

    int n_checks = 0;
    int n_err    = 0;
    int sink_mode = 2;   // 0 always ready, 1 random, 2 stalled
    int acc_cnt  = 0;
    int pop_cnt  = 0;
    int hold_viol = 0;
    bit finished = 0;

    frame_dma_streamer dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_read(mem_read), .mem_addr(mem_addr), .mem_wait(mem_wait),
        .mem_rdata(mem_rdata), .mem_rdv(mem_rdv), .st_data(st_data),
        .st_sop(st_sop), .st_eop(st_eop), .st_empty(st_empty),
        .st_valid(st_valid), .st_ready(st_ready)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Memory model: pixel value is address[16:1], random waits and latency
    logic [31:0] mq[$];
    logic        held = 1'b0;
    logic [31:0] held_addr = '0;
    always @(posedge clk) begin
        logic [31:0] a;
        if (!rst_n) begin
            mem_rdv  <= 1'b0;
            mem_wait <= 1'b0;
            mem_rdata <= '0;
            mq.delete();
            held = 1'b0;
        end else begin
            if (mq.size() > 0 && ($urandom % 4) != 0) begin
                a = mq.pop_front();
                mem_rdv   <= 1'b1;
                mem_rdata <= a[16:1];
            end else begin
                mem_rdv <= 1'b0;
            end
            if (mem_read && held && mem_addr != held_addr) hold_viol++;
            if (mem_read && !mem_wait) begin
                mq.push_back(mem_addr);
                acc_cnt++;
                held = 1'b0;
            end else begin
                held = mem_read;
                held_addr = mem_addr;
            end
            mem_wait <= (($urandom % 3) == 0);
        end
    end

    // Sink: ready pattern chosen by the running scenario
    always @(negedge clk) begin
        if (sink_mode == 0)      st_ready = 1'b1;
        else if (sink_mode == 1) st_ready = 1'(($urandom % 2));
        else                     st_ready = 1'b0;
    end

    // Monitor: record every transferred beat as {eop, sop, data}
    logic [17:0] beats[$];
    always @(posedge clk) begin
        if (rst_n && st_valid && st_ready) begin
            beats.push_back({st_eop, st_sop, st_data});
            pop_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [15:0] pix0(input logic [31:0] addr);
        return addr[16:1];
    endfunction

    // Take one frame off the monitor queue; check order (R3) and markers (R4)
    task automatic get_frame(output logic [15:0] first);
        int w = 0;
        bit order_ok = 1'b1;
        bit mark_ok = 1'b1;
        logic [17:0] b;
        logic [17:0] bad = '0;
        while (beats.size() < NPIX && w < 5000) begin
            @(posedge clk);
            w++;
        end
        if (beats.size() < NPIX) begin
            check(1'b0, "R3", "frame never completed", beats.size(), NPIX);
            first = '1;
            return;
        end
        first = '0;
        for (int i = 0; i < NPIX; i++) begin
            b = beats.pop_front();
            if (i == 0) first = b[15:0];
            if (b[15:0] != first + 16'(i)) begin order_ok = 1'b0; bad = b; end
            if (b[16] != (i == 0) || b[17] != (i == NPIX - 1)) begin
                mark_ok = 1'b0; bad = b;
            end
        end
        check(order_ok, "R3", "pixel order in frame", bad, first);
        check(mark_ok, "R4", "sop/eop markers", bad, 0);
    endtask

    // Frames must move from base old_p to base new_p and never return (R6)
    task automatic drain_to(input logic [15:0] old_p, input logic [15:0] new_p,
                            input string req);
        logic [15:0] f;
        bit seen_new = 1'b0;
        bit ok = 1'b1;
        logic [15:0] bad = '0;
        for (int k = 0; k < 14 && !seen_new; k++) begin
            get_frame(f);
            if (f == new_p) seen_new = 1'b1;
            else if (f != old_p) begin ok = 1'b0; bad = f; end
        end
        get_frame(f);
        if (f != new_p) begin ok = 1'b0; bad = f; end
        check(ok && seen_new, req, "frame base sequence across exchange", bad, new_p);
    endtask

    task automatic wait_clear(output bit ok);
        logic [31:0] d;
        ok = 1'b0;
        for (int k = 0; k < 1000; k++) begin
            reg_read(2'd2, d);
            if (d[0] == 1'b0) begin ok = 1'b1; break; end
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(st_valid == 1'b0, "R1", "valid in reset", st_valid, 0);
        check(st_empty == 1'b0, "R4", "empty tied low", st_empty, 0);
        @(negedge clk);
        rst_n = 1'b1;
        check(st_valid == 1'b0, "R1", "valid after reset", st_valid, 0);
        reg_read(2'd0, d); check(d == FRONT0, "R1", "front after reset", d, FRONT0);
        reg_read(2'd1, d); check(d == BACK0,  "R1", "back after reset", d, BACK0);
        reg_read(2'd2, d); check(d == 0,      "R1", "status after reset", d, 0);
    endtask

    task automatic t_stream();
        logic [15:0] f;
        sink_mode = 1;
        for (int k = 0; k < 2; k++) begin
            get_frame(f);
            check(f == pix0(FRONT0), "R3", "frame base from front", f, pix0(FRONT0));
        end
        sink_mode = 0;
        get_frame(f);
        check(f == pix0(FRONT0), "R3", "frame base, sink always ready", f, pix0(FRONT0));
    endtask

    task automatic t_back_rw();
        logic [31:0] d;
        sink_mode = 2;
        reg_write(2'd1, 32'h0000_3000);
        reg_read(2'd1, d); check(d == 32'h3000, "R2", "back readback", d, 32'h3000);
        reg_read(2'd0, d); check(d == FRONT0, "R2", "front after back write", d, FRONT0);
        reg_read(2'd3, d); check(d == 0, "R2", "spare select reads 0", d, 0);
        reg_read(2'd2, d); check(d == 0, "R2", "status idle", d, 0);
    endtask

    task automatic t_flow();
        logic [15:0] s;
        int inflight;
        sink_mode = 2;
        repeat (100) @(posedge clk);
        @(negedge clk);
        inflight = acc_cnt - pop_cnt;
        check(inflight >= AFULL && inflight <= DEPTH, "R9",
              "fetched minus streamed during stall", inflight, DEPTH);
        s = st_data;
        repeat (5) @(negedge clk);
        check(st_valid && st_data == s, "R10", "beat held while not ready", st_data, s);
        check(acc_cnt - pop_cnt == inflight, "R9", "fetch stopped while full",
              acc_cnt - pop_cnt, inflight);
    endtask

    task automatic t_swap_deferred();
        logic [31:0] d;
        bit ok;
        reg_write(2'd0, 32'hDEAD_BEEF);
        reg_read(2'd2, d); check(d[0] == 1'b1, "R5", "pending after request", d, 1);
        reg_read(2'd0, d); check(d == FRONT0, "R5", "front unchanged by write", d, FRONT0);
        repeat (50) @(posedge clk);
        reg_read(2'd2, d); check(d[0] == 1'b1, "R6", "exchange deferred while stalled", d, 1);
        sink_mode = 1;
        wait_clear(ok);
        check(ok, "R6", "pending clears after frame end", ok, 1);
        reg_read(2'd0, d); check(d == 32'h3000, "R6", "front after exchange", d, 32'h3000);
        reg_read(2'd1, d); check(d == FRONT0, "R6", "back after exchange", d, FRONT0);
        drain_to(pix0(FRONT0), pix0(32'h3000), "R6");
    endtask

    task automatic t_back_while_pending();
        logic [31:0] d;
        bit ok;
        sink_mode = 2;
        repeat (100) @(posedge clk);
        reg_write(2'd0, 32'h0);
        reg_write(2'd1, 32'h0000_5000);
        reg_read(2'd2, d); check(d[0] == 1'b1, "R7", "pending before release", d, 1);
        sink_mode = 1;
        wait_clear(ok);
        check(ok, "R7", "pending clears", ok, 1);
        reg_read(2'd0, d); check(d == 32'h5000, "R7", "latest back moved to front", d, 32'h5000);
        reg_read(2'd1, d); check(d == 32'h3000, "R7", "old front moved to back", d, 32'h3000);
        drain_to(pix0(32'h3000), pix0(32'h5000), "R7");
    endtask

    task automatic t_double_request();
        logic [31:0] d;
        bit ok;
        sink_mode = 2;
        repeat (100) @(posedge clk);
        reg_write(2'd0, 32'h1);
        reg_write(2'd0, 32'h2);
        sink_mode = 1;
        wait_clear(ok);
        check(ok, "R7", "pending clears after double request", ok, 1);
        repeat (300) @(posedge clk);
        reg_read(2'd0, d); check(d == 32'h3000, "R7", "single exchange front", d, 32'h3000);
        reg_read(2'd1, d); check(d == 32'h5000, "R7", "single exchange back", d, 32'h5000);
        reg_read(2'd2, d); check(d == 0, "R7", "no second pending", d, 0);
        drain_to(pix0(32'h5000), pix0(32'h3000), "R7");
        check(hold_viol == 0, "R8", "held request address changes", hold_viol, 0);
    endtask

    initial begin
        rst_n = 1'b0; reg_sel = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        repeat (4) @(posedge clk);
        t_reset();
        t_stream();
        t_back_rw();
        t_flow();
        t_swap_deferred();
        t_back_while_pending();
        t_double_request();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule